// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Controller

This block gives software control over up to 32 general-purpose pins through a small register bus with a 32-bit data path. Every pin can be driven as an output or sampled as an input, and every pin can flag an interrupt. The interrupt can be sensitive to a high level or a low level. It can also fire on a rising edge, a falling edge or on both edges. All pin flags are merged into one interrupt line toward the processor.

Pin inputs cross into the clock domain through a two-stage synchroniser. A third stage keeps the previous synchronised level so that transitions can be seen. Detected events latch into a sticky status register. Software clears them by writing ones to a clear register. An enable mask turns status into pending bits, and the OR of the pending bits drives the interrupt output. The trigger mode is set by three per-pin registers: edge-or-level select, polarity, and a both-edge override. A read-only version word tells software whether the both-edge override exists.

Registers are addressed by a word index, which is the byte offset divided by four. Index 0 is the pin levels, 1 direction, 2 enable, 3 status, 4 pending, 5 clear, 6 edge select, 7 polarity, 8 version and 9 both-edge select. Reads are combinational from the index. Writes take effect at the clock edge on which the write strobe is high.

Top module: `gpio_ctrl`

## Requirements
- R1: Reset leaves every pin an input (direction all ones, `pin_oe` all zero), output levels zero, enable zero, status zero and `irq` low. Edge select resets to all zero and polarity to all ones, so idle low pins start in active-high level mode.
- R2: In the direction register (index 1), bit value 1 makes the pin an input and 0 makes it an output. `pin_oe[k]` is high exactly when bit k is 0. `pin_out` carries the value last written to index 0.
- R3: Reading index 0 returns, for an input pin, its synchronised level, which reflects a change two clock edges later. For an output pin it returns the driven level.
- R4: With edge-select bit 0 (index 6), the pin is level-sensitive. Polarity 1 (index 7) sets its status bit (index 3) while the synchronised level is high, and polarity 0 sets it while the level is low.
- R5: With edge-select bit 1 and both-edge bit 0 (index 9), polarity 1 flags a rising transition and polarity 0 a falling one. The status bit is visible after the third clock edge following the pin change.
- R6: With edge-select bit 1 and both-edge bit 1, any transition sets the status bit whatever the polarity. With edge-select 0, the both-edge bit has no effect.
- R7: Writing index 5 clears each status bit whose written bit is 1. Bits written 0 leave status unchanged, and index 5 reads as zero.
- R8: A level-sensitive status bit that is cleared while its pin is still active reads 0 for one cycle and then sets again. An edge event detected in the same cycle as its clear keeps the bit set.
- R9: Pending (index 4) reads status AND enable (index 2), and `irq` is the OR of pending. Writing enable to zero drops `irq` while status keeps latching. Restoring enable raises `irq` for the events latched meanwhile.
- R10: Index 8 reads the constant VERSION (default 3). Writes to status, pending and version have no effect.
- R11: A status bit stays set after its trigger condition goes away, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| reg_idx | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `reg_idx` |
| pin_in | input | N | Pad input levels |
| pin_out | output | N | Output levels |
| pin_oe | output | N | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
Two functions can land on the same clock edge: the software clear of a status bit and a fresh detection on that same pin. The bench changes an edge-mode pin and asserts the clear strobe exactly three edges later, which is the edge on which the event latches. It then expects the bit to survive. For a level-mode pin that is still active, it expects the bit to read 0 right after the clear and 1 one cycle later.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  typedef enum logic [3:0] {
    W_LEVELS = 4'd0,
    W_DIR    = 4'd1,
    W_ENA    = 4'd2,
    W_STAT   = 4'd3,
    W_PEND   = 4'd4,
    W_CLR    = 4'd5,
    W_EDGE   = 4'd6,
    W_POL    = 4'd7,
    W_VER    = 4'd8,
    W_DUAL   = 4'd9
  } word_e;

  // active level for a level-sensitive pin
  function automatic logic level_active(input logic pol, input logic cur);
    return pol ? cur : ~cur;
  endfunction

  // transition match for an edge-sensitive pin
  function automatic logic edge_seen(input logic pol, input logic dual,
                                     input logic cur, input logic prev);
    if (dual) return cur ^ prev;
    return pol ? (cur & ~prev) : (prev & ~cur);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign cur  = s2_q;
  assign prev = s3_q;
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger
  import gpio_ctrl_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] cur,
  input  logic [N-1:0] prev,
  input  logic [N-1:0] edge_sel,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] dual,
  output logic [N-1:0] edge_hit,
  output logic [N-1:0] level_hit
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    assign edge_hit[i]  = edge_sel[i] & edge_seen(pol[i], dual[i], cur[i], prev[i]);
    assign level_hit[i] = ~edge_sel[i] & level_active(pol[i], cur[i]);
  end
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] edge_hit,
  input  logic [N-1:0] level_hit,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] ena,
  output logic [N-1:0] stat,
  output logic [N-1:0] pend
);
  logic [N-1:0] stat_q;

  // clear beats a level hit for one cycle; an edge hit always lands
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | edge_hit | (level_hit & ~clr_mask);
  end

  assign stat = stat_q;
  assign pend = stat_q & ena;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int N       = 32,
  parameter int VERSION = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [3:0]   reg_idx,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe,
  output logic         irq
);
  localparam bit HAS_DUAL = (VERSION >= 3);

  logic [N-1:0] out_q, dir_q, ena_q, edge_q, pol_q, dual_q;
  logic [N-1:0] dual_eff, sync_cur, sync_prev;
  logic [N-1:0] edge_hit, level_hit, clr_mask, stat_q, pend;
  logic [N-1:0] wd, levels;
  word_e        widx;

  assign widx = word_e'(reg_idx);
  assign wd   = bus_wdata[N-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      ena_q  <= '0;
      edge_q <= '0;
      pol_q  <= '1;
      dual_q <= '0;
    end else if (bus_wr) begin
      unique case (widx)
        W_LEVELS: out_q  <= wd;
        W_DIR:    dir_q  <= wd;
        W_ENA:    ena_q  <= wd;
        W_EDGE:   edge_q <= wd;
        W_POL:    pol_q  <= wd;
        W_DUAL:   dual_q <= wd;
        default:  ;
      endcase
    end
  end

  if (HAS_DUAL) begin : g_dual
    assign dual_eff = dual_q;
  end else begin : g_nodual
    assign dual_eff = '0;
  end

  assign clr_mask = (bus_wr && widx == W_CLR) ? wd : '0;

  gpio_sync #(.N(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur(sync_cur), .prev(sync_prev)
  );

  gpio_trigger #(.N(N)) u_trig (
    .cur(sync_cur), .prev(sync_prev), .edge_sel(edge_q), .pol(pol_q),
    .dual(dual_eff), .edge_hit(edge_hit), .level_hit(level_hit)
  );

  gpio_status #(.N(N)) u_stat (
    .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit), .level_hit(level_hit),
    .clr_mask(clr_mask), .ena(ena_q), .stat(stat_q), .pend(pend)
  );

  assign levels = (sync_cur & dir_q) | (out_q & ~dir_q);

  always_comb begin
    bus_rdata = '0;
    unique case (widx)
      W_LEVELS: bus_rdata = 32'(levels);
      W_DIR:    bus_rdata = 32'(dir_q);
      W_ENA:    bus_rdata = 32'(ena_q);
      W_STAT:   bus_rdata = 32'(stat_q);
      W_PEND:   bus_rdata = 32'(pend);
      W_EDGE:   bus_rdata = 32'(edge_q);
      W_POL:    bus_rdata = 32'(pol_q);
      W_VER:    bus_rdata = 32'(VERSION);
      W_DUAL:   bus_rdata = 32'(dual_eff);
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
  assign irq     = |pend;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int N       = 32,
  parameter int VERSION = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [3:0]   reg_idx,
  input logic [31:0]  bus_wdata,
  input logic [31:0]  bus_rdata,
  input logic [N-1:0] pin_oe,
  input logic         irq,
  input logic [N-1:0] stat_q,
  input logic [N-1:0] ena_q,
  input logic [N-1:0] edge_q,
  input logic [N-1:0] dual_eff,
  input logic [N-1:0] edge_hit,
  input logic [N-1:0] clr_mask,
  input logic [N-1:0] sync_cur,
  input logic [N-1:0] sync_prev
);
  AST_DIR_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && reg_idx == W_DIR) |=> (pin_oe == ~$past(bus_wdata[N-1:0]))); // R2

  AST_DUAL_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_q & dual_eff & (sync_cur ^ sync_prev) & ~edge_hit) == '0)); // R6

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && reg_idx == W_CLR) |=>
      ((stat_q & $past(bus_wdata[N-1:0]) & ~$past(edge_hit)) == '0)); // R7

  AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit))); // R8

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> !irq); // R9

  AST_VERSION: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == W_VER) |-> (bus_rdata == 32'(VERSION))); // R10

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (1'b1) |=> ((($past(stat_q) & ~$past(clr_mask)) & ~stat_q) == '0)); // R11
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.N(N), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .reg_idx(reg_idx),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_oe(pin_oe), .irq(irq),
  .stat_q(stat_q), .ena_q(ena_q), .edge_q(edge_q), .dual_eff(dual_eff),
  .edge_hit(edge_hit), .clr_mask(clr_mask), .sync_cur(sync_cur),
  .sync_prev(sync_prev)
);

// File: tb/tb_gpio_ctrl.sv
module tb_gpio_ctrl;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [3:0]   reg_idx = 4'd0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic         irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_ctrl #(.N(N), .VERSION(3)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .reg_idx(reg_idx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // register word indices, as listed in the requirements
  localparam logic [3:0] I_LEV = 0, I_DIR = 1, I_ENA = 2, I_STAT = 3, I_PEND = 4,
                         I_CLR = 5, I_EDGE = 6, I_POL = 7, I_VER = 8, I_DUAL = 9;

  // {edge, pol, dual, level before, level after, expected status bit}
  localparam logic [5:0] VEC [12] = '{
    6'b010_01_1, 6'b010_10_0,   // R4 level high
    6'b000_10_1, 6'b000_01_0,   // R4 level low
    6'b110_01_1, 6'b110_10_0,   // R5 rising
    6'b100_10_1, 6'b100_01_0,   // R5 falling
    6'b101_01_1, 6'b111_10_1,   // R6 both edges, polarity ignored
    6'b111_11_0, 6'b011_01_1    // R6 no transition / dual ignored in level mode
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_idx = idx; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] idx, output logic [31:0] d);
    reg_idx = idx;
    #1;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);

    // R1 reset state
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
    check("R1 pin_out", 32'(pin_out), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    bus_read(I_STAT, rd); check("R1 status", rd, 32'h0);
    bus_read(I_DIR, rd);  check("R1 direction", rd, 32'hFFFF_FFFF);
    bus_read(I_POL, rd);  check("R1 polarity", rd, 32'hFFFF_FFFF);

    // trigger-mode table on pin 0
    for (int v = 0; v < 12; v++) begin
      logic e, p, d, a, b, x;
      {e, p, d, a, b, x} = VEC[v];
      pin_in[0] = a;
      wait_clk(4);
      bus_write(I_EDGE, {31'h0, e});
      bus_write(I_POL, {31'h7FFF_FFFF, p});
      bus_write(I_DUAL, {31'h0, d});
      bus_write(I_CLR, 32'hFFFF_FFFF);
      pin_in[0] = b;
      wait_clk(4);
      if (!e) begin
        bus_write(I_CLR, 32'h1);
        wait_clk(2);
      end
      bus_read(I_STAT, rd);
      check(e ? (d ? "R6 vector" : "R5 vector") : "R4 vector", {31'h0, rd[0]}, {31'h0, x});
    end

    bus_write(I_EDGE, 32'h0);
    bus_write(I_POL, 32'hFFFF_FFFF);
    bus_write(I_DUAL, 32'h0);
    pin_in = '0;
    wait_clk(4);
    bus_write(I_CLR, 32'hFFFF_FFFF);

    // R2 direction and output value
    bus_write(I_DIR, 32'hFFFF_FFF0);
    bus_write(I_LEV, 32'h0000_0005);
    check("R2 pin_oe", 32'(pin_oe), 32'h0000_000F);
    check("R2 pin_out", 32'(pin_out), 32'h0000_0005);

    // R3 pin levels read back
    pin_in = 32'h0000_00A0;
    wait_clk(3);
    bus_read(I_LEV, rd);
    check("R3 levels", rd & 32'hFF, 32'h0000_00A5);

    // R11 sticky after pin 5 goes inactive
    pin_in = 32'h0000_0080;
    wait_clk(4);
    bus_read(I_STAT, rd);
    check("R11 sticky", rd, 32'h0000_00A0);

    // R7 clear by ones, zeros ignored, reads zero
    bus_write(I_CLR, 32'h0000_0020);
    wait_clk(2);
    bus_read(I_STAT, rd); check("R7 clear one bit", rd, 32'h0000_0080);
    bus_write(I_CLR, 32'h0);
    bus_read(I_STAT, rd); check("R7 zero write", rd, 32'h0000_0080);
    bus_read(I_CLR, rd);  check("R7 clear reads zero", rd, 32'h0);
    pin_in = '0;
    wait_clk(4);
    bus_write(I_CLR, 32'hFFFF_FFFF);
    wait_clk(2);

    // R10 version and read-only words
    bus_read(I_VER, rd); check("R10 version", rd, 32'd3);
    bus_write(I_VER, 32'h77);
    bus_read(I_VER, rd); check("R10 version write", rd, 32'd3);
    bus_write(I_STAT, 32'hFFFF);
    bus_read(I_STAT, rd); check("R10 status write", rd, 32'h0);
    bus_write(I_PEND, 32'hFF);
    bus_read(I_PEND, rd); check("R10 pending write", rd, 32'h0);

    // R9 pending, masking and re-arm
    bus_write(I_EDGE, 32'h0000_0300);
    pin_in[9:8] = 2'b11;
    wait_clk(4);
    bus_read(I_STAT, rd); check("R5 two rising pins", rd, 32'h0000_0300);
    bus_write(I_ENA, 32'h0000_0100);
    check("R9 irq raised", 32'(irq), 32'h1);
    bus_read(I_PEND, rd); check("R9 pending", rd, 32'h0000_0100);
    bus_write(I_ENA, 32'h0);
    check("R9 irq masked", 32'(irq), 32'h0);
    bus_write(I_CLR, 32'h0000_0300);
    pin_in[9:8] = 2'b00;
    wait_clk(4);
    pin_in[9:8] = 2'b11;
    wait_clk(4);
    check("R9 irq masked while latching", 32'(irq), 32'h0);
    bus_write(I_ENA, 32'h0000_0300);
    check("R9 irq re-armed", 32'(irq), 32'h1);
    bus_read(I_PEND, rd); check("R9 pending kept", rd, 32'h0000_0300);
    bus_write(I_ENA, 32'h0);

    // R8 edge event and clear on the same edge
    bus_write(I_EDGE, 32'h0000_0B00);
    bus_write(I_CLR, 32'hFFFF_FFFF);
    @(negedge clk); pin_in[11] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_idx = I_CLR; bus_wdata = 32'h0000_0800; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    bus_read(I_STAT, rd); check("R8 edge beats clear", rd & 32'h800, 32'h800);
    bus_write(I_CLR, 32'h0000_0800);
    bus_read(I_STAT, rd); check("R7 later clear", rd & 32'h800, 32'h0);

    // R8 level pin still active re-sets one cycle after clear
    pin_in[12] = 1'b1;
    wait_clk(4);
    bus_write(I_CLR, 32'h0000_1000);
    bus_read(I_STAT, rd); check("R8 level cleared", rd & 32'h1000, 32'h0);
    @(negedge clk);
    bus_read(I_STAT, rd); check("R8 level re-set", rd & 32'h1000, 32'h1000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule